// File: doc/BRIEF.md
# Shadow Register Default Reload Controller

This block restores two banks of control registers to their default contents after system events. The brightness bank (53 registers) is cleared to zero on some events. On others it is rebuilt from a nonvolatile shadow copy. The current/configuration bank (48 registers) is always rebuilt from the shadow copy. The shadow copy is modelled as a constant table computed from the address.

Each event arrives as a one-cycle pulse. The block turns it into a pending request for each bank it affects. A single walker then issues one register write per clock, ascending through that bank's addresses, on a write strobe with address and data. The register file that receives the strobes is outside the block. A busy flag covers every cycle in which a request is pending or a pass is running. Requests that arrive during a pass wait in a per-bank slot and run afterwards.

Top module: `rsr_reload_ctrl`

## Requirements
- R1: While reset is asserted, and after reset with no event, `busy` and `wr_en` stay low and no write is issued.
- R2: A pulse on `evt_por`, `evt_en_toggle` or `evt_regdef` makes a pass over the brightness bank that writes 00h to each of its addresses.
- R3: A pulse on `evt_wdt_ovf`, `evt_force_fs`, `evt_load_cmd` or `evt_prog_entry` makes a brightness-bank pass that writes the shadow byte to each address.
- R4: A pulse on `evt_por`, `evt_en_toggle`, `evt_uv_restart` or `evt_wdt_ovf` makes a current/configuration-bank pass that writes the shadow byte to each address.
- R5: A brightness pass writes addresses 00h–17h, then 20h–37h, then 40h–44h. A current/configuration pass writes 50h–67h, then 70h–87h. Writes come one per clock with no gap, and queued passes follow with no gap.
- R6: When a clearing event and a shadow-load event reach the brightness bank in the same cycle, one shadow-load pass runs and no clearing pass runs.
- R7: An event that arrives while a pass runs, including one for the bank being written, is kept and served as a full pass after the current one.
- R8: When both banks hold a request and the walker is free, the brightness bank goes first.
- R9: `busy` rises in the cycle after an event pulse. The first write follows one cycle later. `busy` falls in the cycle after the last write of the last pass.
- R10: `evt_uv_restart` never writes the brightness bank. `evt_regdef`, `evt_force_fs`, `evt_load_cmd` and `evt_prog_entry` never write the current/configuration bank.
- R11: The shadow byte for address A is A with its two nibbles swapped, XOR `SHADOW_SEED` (default 3Ch).
- R12: A request that has not yet started is replaced by a newer request for the same bank. A queued shadow load followed by a clear results in a clearing pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the block's own state |
| evt_por | input | 1 | Power-on reset event pulse |
| evt_en_toggle | input | 1 | Enable-pin restart event pulse |
| evt_uv_restart | input | 1 | Supply or regulator undervoltage restart pulse |
| evt_wdt_ovf | input | 1 | Watchdog overflow fail-safe entry pulse |
| evt_force_fs | input | 1 | Software-forced fail-safe pulse |
| evt_load_cmd | input | 1 | Shadow load command pulse |
| evt_prog_entry | input | 1 | Program-mode entry pulse |
| evt_regdef | input | 1 | Register-default command pulse |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Data for the write |
| busy | output | 1 | Request pending or pass in progress |

## Verification
The hardest cases are collisions. A clear and a load in the same cycle must yield only a load; a design that let the clear win would write zeros where shadow bytes belong. An event during a pass must wait for the pass to end: a lost request shows up as a missing pass, and a restarted walker as a truncated one. A clear that arrives after a queued load must replace it, or stale shadow data would land in the bank. The bench compares the full write log of each scenario, including the gaps between the three brightness segments and the absence of cycles between back-to-back passes. It also checks the exact cycles in which `busy` rises and falls.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int NGRP = 2;
  localparam int NSEG = 3;

  // group 0: brightness bank, group 1: current/configuration bank
  localparam logic [AW-1:0] SEG_BASE [NGRP][NSEG] = '{
    '{8'h00, 8'h20, 8'h40},
    '{8'h50, 8'h70, 8'h00}
  };
  localparam int SEG_LEN [NGRP][NSEG] = '{
    '{24, 24, 5},
    '{24, 24, 0}
  };

  function automatic int grp_len(input int g);
    int n;
    n = 0;
    for (int s = 0; s < NSEG; s++) n += SEG_LEN[g][s];
    return n;
  endfunction

  function automatic int max_len();
    int m;
    m = 1;
    for (int g = 0; g < NGRP; g++) if (grp_len(g) > m) m = grp_len(g);
    return m;
  endfunction

  localparam int MAXLEN = max_len();
  localparam int IW     = $clog2(MAXLEN);
  localparam int GW     = (NGRP > 1) ? $clog2(NGRP) : 1;

  // position inside a group -> register address
  function automatic logic [AW-1:0] idx_to_addr(input int g, input int idx);
    logic [AW-1:0] a;
    int            rem;
    logic          hit;
    a   = '0;
    rem = idx;
    hit = 1'b0;
    for (int s = 0; s < NSEG; s++) begin
      if (!hit && rem < SEG_LEN[g][s]) begin
        a   = SEG_BASE[g][s] + AW'(rem);
        hit = 1'b1;
      end else if (!hit) begin
        rem = rem - SEG_LEN[g][s];
      end
    end
    return a;
  endfunction

  // shadow content: nibble swap of the address, then xor with a seed
  function automatic logic [DW-1:0] shadow_byte(input logic [AW-1:0] a,
                                                input logic [DW-1:0] seed);
    return {a[3:0], a[7:4]} ^ seed;
  endfunction

endpackage

// File: rtl/rsr_event_map.sv
module rsr_event_map
  import rsr_pkg::*;
(
  input  logic            evt_por,
  input  logic            evt_en_toggle,
  input  logic            evt_uv_restart,
  input  logic            evt_wdt_ovf,
  input  logic            evt_force_fs,
  input  logic            evt_load_cmd,
  input  logic            evt_prog_entry,
  input  logic            evt_regdef,
  output logic [NGRP-1:0] req_clr,
  output logic [NGRP-1:0] req_ld
);

  always_comb begin
    // brightness bank
    req_clr[0] = evt_por | evt_en_toggle | evt_regdef;
    req_ld[0]  = evt_wdt_ovf | evt_force_fs | evt_load_cmd | evt_prog_entry;
    // current/configuration bank: shadow reload only
    req_clr[1] = 1'b0;
    req_ld[1]  = evt_por | evt_en_toggle | evt_uv_restart | evt_wdt_ovf;
  end

endmodule

// File: rtl/rsr_pend_slot.sv
module rsr_pend_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic req_clr,
  input  logic req_ld,
  input  logic take,
  output logic vld,
  output logic ld
);

  logic req_any;
  assign req_any = req_clr | req_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      ld  <= 1'b0;
    end else if (req_any) begin
      // newest request replaces a waiting one; a load beats a same-cycle clear
      vld <= 1'b1;
      ld  <= req_ld;
    end else if (take) begin
      vld <= 1'b0;
    end
  end

endmodule

// File: rtl/rsr_walker.sv
module rsr_walker
  import rsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] pend_vld,
  input  logic [NGRP-1:0] pend_ld,
  output logic [NGRP-1:0] take,
  output logic            active,
  output logic [GW-1:0]   cur_grp,
  output logic            cur_ld,
  output logic [IW-1:0]   idx,
  output logic            last
);

  logic          free;
  logic          any_pend;
  logic [GW-1:0] pick;

  assign last     = active && (int'(idx) == grp_len(int'(cur_grp)) - 1);
  assign free     = !active || last;
  assign any_pend = |pend_vld;

  // lowest-numbered pending group wins
  always_comb begin
    pick = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (pend_vld[g]) pick = GW'(g);
    end
  end

  always_comb begin
    take = '0;
    if (free && any_pend) take[pick] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cur_grp <= '0;
      cur_ld  <= 1'b0;
      idx     <= '0;
    end else if (free && any_pend) begin
      active  <= 1'b1;
      cur_grp <= pick;
      cur_ld  <= pend_ld[pick];
      idx     <= '0;
    end else if (last) begin
      active  <= 1'b0;
      idx     <= '0;
    end else if (active) begin
      idx     <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/rsr_shadow_rom.sv
module rsr_shadow_rom
  import rsr_pkg::*;
#(
  parameter logic [DW-1:0] SEED = 8'h3C
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  assign data = shadow_byte(addr, SEED);

endmodule

// File: rtl/rsr_reload_ctrl.sv
module rsr_reload_ctrl
  import rsr_pkg::*;
#(
  parameter logic [DW-1:0] SHADOW_SEED = 8'h3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_por,
  input  logic          evt_en_toggle,
  input  logic          evt_uv_restart,
  input  logic          evt_wdt_ovf,
  input  logic          evt_force_fs,
  input  logic          evt_load_cmd,
  input  logic          evt_prog_entry,
  input  logic          evt_regdef,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy
);

  logic [NGRP-1:0] req_clr;
  logic [NGRP-1:0] req_ld;
  logic [NGRP-1:0] pend_vld;
  logic [NGRP-1:0] pend_ld;
  logic [NGRP-1:0] take;
  logic            walk_active;
  logic [GW-1:0]   walk_grp;
  logic            walk_ld;
  logic [IW-1:0]   walk_idx;
  logic            walk_last;
  logic [DW-1:0]   rom_data;

  rsr_event_map u_map (
    .evt_por        (evt_por),
    .evt_en_toggle  (evt_en_toggle),
    .evt_uv_restart (evt_uv_restart),
    .evt_wdt_ovf    (evt_wdt_ovf),
    .evt_force_fs   (evt_force_fs),
    .evt_load_cmd   (evt_load_cmd),
    .evt_prog_entry (evt_prog_entry),
    .evt_regdef     (evt_regdef),
    .req_clr        (req_clr),
    .req_ld         (req_ld)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_slot
    rsr_pend_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_clr (req_clr[g]),
      .req_ld  (req_ld[g]),
      .take    (take[g]),
      .vld     (pend_vld[g]),
      .ld      (pend_ld[g])
    );
  end

  rsr_walker u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_vld (pend_vld),
    .pend_ld  (pend_ld),
    .take     (take),
    .active   (walk_active),
    .cur_grp  (walk_grp),
    .cur_ld   (walk_ld),
    .idx      (walk_idx),
    .last     (walk_last)
  );

  assign wr_addr = idx_to_addr(int'(walk_grp), int'(walk_idx));

  rsr_shadow_rom #(.SEED(SHADOW_SEED)) u_rom (
    .addr (wr_addr),
    .data (rom_data)
  );

  assign wr_en   = walk_active;
  assign wr_data = walk_ld ? rom_data : '0;
  assign busy    = walk_active | (|pend_vld);

endmodule

// File: rtl/rsr_reload_chk.sv
module rsr_reload_chk
  import rsr_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            walk_last,
  input logic            walk_ld,
  input logic [NGRP-1:0] take
);

  // R9
  wr_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R9
  busy_ends_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wr_en));

  // R2
  clear_writes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !walk_ld) |-> (wr_data == '0));

  // R5
  addr_ascends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && !$past(walk_last)) |-> (wr_addr > $past(wr_addr)));

  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);

endmodule

bind rsr_reload_ctrl rsr_reload_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .walk_last (walk_last),
  .walk_ld   (walk_ld),
  .take      (take)
);

// File: tb/tb_rsr_reload_ctrl.sv
module tb_rsr_reload_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = 8'h00; // [0]por [1]en [2]uv [3]wdt [4]force [5]load [6]prog [7]regdef
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       busy;

  always #4 clk = ~clk;

  rsr_reload_ctrl dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_por        (evt[0]),
    .evt_en_toggle  (evt[1]),
    .evt_uv_restart (evt[2]),
    .evt_wdt_ovf    (evt[3]),
    .evt_force_fs   (evt[4]),
    .evt_load_cmd   (evt[5]),
    .evt_prog_entry (evt[6]),
    .evt_regdef     (evt[7]),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .busy           (busy)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int nlog = 0;
  int nexp = 0;
  logic [7:0] log_a [0:1023];
  logic [7:0] log_d [0:1023];
  int         log_c [0:1023];
  logic [7:0] exp_a [0:1023];
  logic [7:0] exp_d [0:1023];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && wr_en && nlog < 1024) begin
      log_a[nlog] = wr_addr;
      log_d[nlog] = wr_data;
      log_c[nlog] = cyc;
      nlog = nlog + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] shadow_of(input logic [7:0] a);
    logic [7:0] sw;
    sw = ((a << 4) | (a >> 4)) & 8'hFF;
    return sw ^ 8'h3C;
  endfunction

  task automatic push_range(input int lo, input int hi, input bit load);
    for (int a = lo; a <= hi; a++) begin
      exp_a[nexp] = 8'(a);
      exp_d[nexp] = load ? shadow_of(8'(a)) : 8'h00;
      nexp++;
    end
  endtask

  // expected pass: grp 0 brightness, grp 1 current/configuration
  task automatic expect_pass(input int grp, input bit load);
    if (grp == 0) begin
      push_range('h00, 'h17, load);
      push_range('h20, 'h37, load);
      push_range('h40, 'h44, load);
    end else begin
      push_range('h50, 'h67, load);
      push_range('h70, 'h87, load);
    end
  endtask

  task automatic clear_log();
    nlog = 0;
    nexp = 0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    evt = m;
    @(negedge clk);
    evt = 8'h00;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk);
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string req);
    bit bad_a;
    bit bad_d;
    bit bad_c;
    bad_a = 0; bad_d = 0; bad_c = 0;
    check(nlog == nexp, req, "write count", nlog, nexp);
    for (int i = 0; i < nlog && i < nexp; i++) begin
      if (!bad_a && log_a[i] !== exp_a[i]) begin
        bad_a = 1;
        check(0, req, $sformatf("addr of write %0d", i), int'(log_a[i]), int'(exp_a[i]));
      end
      if (!bad_d && log_d[i] !== exp_d[i]) begin
        bad_d = 1;
        check(0, req, $sformatf("data of write %0d at %0h", i, exp_a[i]),
              int'(log_d[i]), int'(exp_d[i]));
      end
      if (!bad_c && log_c[i] != log_c[0] + i) begin
        bad_c = 1;
        check(0, "R5", $sformatf("cycle of write %0d", i), log_c[i] - log_c[0], i);
      end
    end
    check(!bad_a, req, "address sequence", 0, 0);
    check(!bad_d, req, "data sequence", 0, 0);
    check(!bad_c, "R5", "writes back to back", 0, 0);
  endtask

  task automatic t_reset();
    check(busy == 1'b0 && wr_en == 1'b0, "R1", "busy/wr_en in reset", {busy, wr_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_log();
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R1", "busy idle after reset", int'(busy), 0);
    check(nlog == 0, "R1", "writes after reset", nlog, 0);
  endtask

  task automatic t_regdef_clear();
    clear_log();
    @(negedge clk);
    evt = 8'h80;
    @(negedge clk);
    evt = 8'h00;
    // R9: busy one cycle after the pulse, write one cycle later
    check(busy == 1'b1 && wr_en == 1'b0, "R9", "busy first cycle", {busy, wr_en}, 2);
    @(negedge clk);
    check(wr_en == 1'b1 && wr_addr == 8'h00, "R9", "first write", {wr_en, wr_addr}, 'h100);
    repeat (52) @(negedge clk);
    check(busy == 1'b1 && wr_en == 1'b1, "R9", "busy on last write", {busy, wr_en}, 3);
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after last write", int'(busy), 0);
    wait_idle();
    expect_pass(0, 0);
    compare("R2 R10 regdef");
  endtask

  task automatic t_single(input logic [7:0] m, input string req,
                          input int g0, input bit l0, input int g1, input bit l1);
    clear_log();
    pulse(m);
    wait_idle();
    if (g0 >= 0) expect_pass(g0, l0);
    if (g1 >= 0) expect_pass(g1, l1);
    compare(req);
  endtask

  task automatic t_same_cycle();
    // R6: regdef and load command together
    t_single(8'hA0, "R6 clear+load", 0, 1, -1, 0);
    // R6: enable restart and force fail-safe together
    t_single(8'h12, "R6 en+force", 0, 1, 1, 1);
  endtask

  task automatic t_queue_same_group();
    clear_log();
    pulse(8'h10);
    repeat (10) @(negedge clk);
    pulse(8'h10);
    wait_idle();
    expect_pass(0, 1);
    expect_pass(0, 1);
    compare("R7 queued repeat");
  endtask

  task automatic t_queue_replace();
    clear_log();
    pulse(8'h04);
    repeat (5) @(negedge clk);
    pulse(8'h20);
    repeat (5) @(negedge clk);
    pulse(8'h80);
    wait_idle();
    expect_pass(1, 1);
    expect_pass(0, 0);
    compare("R12 replace");
  endtask

  task automatic t_cross_queue();
    clear_log();
    pulse(8'h40);
    repeat (20) @(negedge clk);
    pulse(8'h04);
    wait_idle();
    expect_pass(0, 1);
    expect_pass(1, 1);
    compare("R7 cross queue");
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();                                  // R1
    t_regdef_clear();                           // R2 R9 R10
    t_single(8'h01, "R2 R4 R8 por", 0, 0, 1, 1);
    t_single(8'h02, "R2 R4 R8 en", 0, 0, 1, 1);
    t_single(8'h04, "R4 R10 uv", 1, 1, -1, 0);
    t_single(8'h08, "R3 R4 R8 R11 wdt", 0, 1, 1, 1);
    t_single(8'h10, "R3 R10 R11 force", 0, 1, -1, 0);
    t_single(8'h20, "R3 R10 load", 0, 1, -1, 0);
    t_single(8'h40, "R3 R10 prog", 0, 1, -1, 0);
    t_same_cycle();                             // R6
    t_queue_same_group();                       // R7
    t_cross_queue();                            // R7 R8
    t_queue_replace();                          // R12
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule